// File: doc/BRIEF.md
# Memory-Protection Fault Status Capture

This block keeps the sticky record of memory-protection faults raised by a processor core. The core reports four kinds of violation as single-cycle event pulses: an instruction fetch from a non-executable region, a data load or store to a location that forbids it, an access failure while stacking context on exception entry, and one while unstacking on exception return. A fifth event reports a failure during deferred floating-point context stacking. Each event sets its own flag in an 8-bit status register. Only a data violation also loads its access address into a 32-bit fault-address register, and it then sets an address-valid flag.

Software reads both registers and clears flags through a small register port. A write of 1 to a flag clears it. The address-valid flag is cleared the same way, so a fault handler can mark a captured address as stale. A level output tells an external fault-request path whether any violation flag is still set.

Top module: `mpu_fault_status`

## Requirements
- R1: After reset the status register reads 0x00, the fault-address register reads 0 and `fault_pending_o` is low.
- R2: An event pulse sets its status bit at the next clock edge: bit 0 for an instruction-fetch violation, bit 1 for a data violation, bit 3 for an unstacking violation, bit 4 for a stacking violation and bit 5 for a floating-point stacking violation. The bit stays set until it is cleared.
- R3: Status bits 2 and 6 always read 0, and writes to them have no effect.
- R4: A write to the status register (`reg_addr_i` = 0) clears every implemented bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: A data violation loads `data_addr_i` into the fault-address register (`reg_addr_i` = 1) and sets status bit 7, the address-valid flag.
- R6: An instruction-fetch, stacking, unstacking or floating-point stacking violation does not change the fault-address register or bit 7.
- R7: When an event and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set. A data violation also captures its address in that case.
- R8: A data violation that arrives while bit 7 is already set replaces the captured address with the new one, and bit 7 stays set.
- R9: The fault-address register is read-only. A write to offset 1 changes neither the fault-address register nor the status register.
- R10: `fault_pending_o` is high exactly when any of status bits 0, 1, 3, 4 or 5 is set. Bit 7 alone does not raise it.
- R11: Clearing bit 7 with a write does not change the captured address value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ifetch_fault_i | input | 1 | Instruction-fetch violation pulse |
| data_fault_i | input | 1 | Data load/store violation pulse |
| data_addr_i | input | 32 | Address of the violating data access |
| stack_fault_i | input | 1 | Exception-entry stacking violation pulse |
| unstack_fault_i | input | 1 | Exception-return unstacking violation pulse |
| fpstack_fault_i | input | 1 | Floating-point context stacking violation pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 = status, 1 = fault address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the selected register, combinational |
| fault_pending_o | output | 1 | High while any violation flag is set |

## Verification
A fault event and a software clear can hit the same status bit in the same cycle. The bench raises a data violation on the same clock edge as a status write of 0x82. It then expects bit 1 and the valid flag to stay set and the new address to be captured. A second collision happens when a data violation arrives while the valid flag is already set. The bench judges that case by reading back the newer address with the flag still set.

// File: rtl/mpu_fault_pkg.sv
package mpu_fault_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_IF   = 0;
  localparam int BIT_DATA = 1;
  localparam int BIT_UNST = 3;
  localparam int BIT_STK  = 4;
  localparam int BIT_FPS  = 5;
  localparam int BIT_VLD  = 7;
  localparam logic [STAT_W-1:0] FAULT_MASK = 8'h3B;
  localparam logic [STAT_W-1:0] IMPL_MASK  = 8'hBB;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ADDR   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mpu_fault_flags.sv
module mpu_fault_flags #(
  parameter int               N    = 8,
  parameter logic [N-1:0]     IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    if (IMPL[b]) begin : g_impl
      logic q;
      // set has priority over a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[b]) q <= 1'b1;
        else if (clr_i[b]) q <= 1'b0;
      end
      assign flags_o[b] = q;

      AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[b] |=> flags_o[b]); // R7
      AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[b] && !set_i[b]) |=> !flags_o[b]); // R4
      AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i[b] && !set_i[b]) |=> $stable(flags_o[b])); // R2
    end else begin : g_rsvd
      logic unused_b;
      assign unused_b   = set_i[b] ^ clr_i[b];
      assign flags_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/mpu_fault_addr.sv
module mpu_fault_addr #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (capture_i) addr_q <= addr_i;
  end
  assign addr_o = addr_q;

  AST_ADDR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> addr_o == $past(addr_i)); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(addr_o)); // R6
endmodule

// File: rtl/mpu_fault_status.sv
module mpu_fault_status
  import mpu_fault_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ifetch_fault_i,
  input  logic          data_fault_i,
  input  logic [AW-1:0] data_addr_i,
  input  logic          stack_fault_i,
  input  logic          unstack_fault_i,
  input  logic          fpstack_fault_i,
  input  logic          reg_wr_i,
  input  logic          reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          fault_pending_o
);
  logic [STAT_W-1:0] set_vec, clr_vec, status;
  logic [AW-1:0]     fault_addr;
  logic              unused_w;

  assign unused_w = ^reg_wdata_i[DW-1:STAT_W];

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_IF]   = ifetch_fault_i;
    set_vec[BIT_DATA] = data_fault_i;
    set_vec[BIT_UNST] = unstack_fault_i;
    set_vec[BIT_STK]  = stack_fault_i;
    set_vec[BIT_FPS]  = fpstack_fault_i;
    set_vec[BIT_VLD]  = data_fault_i;
  end

  assign clr_vec = (reg_wr_i && reg_sel_e'(reg_addr_i) == SEL_STATUS)
                   ? reg_wdata_i[STAT_W-1:0] : '0;

  mpu_fault_flags #(.N(STAT_W), .IMPL(IMPL_MASK)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (status)
  );

  mpu_fault_addr #(.AW(AW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (data_fault_i),
    .addr_i    (data_addr_i),
    .addr_o    (fault_addr)
  );

  always_comb begin
    if (reg_sel_e'(reg_addr_i) == SEL_ADDR) reg_rdata_o = DW'(fault_addr);
    else                                    reg_rdata_o = DW'(status);
  end

  assign fault_pending_o = |(status & FAULT_MASK);

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 1'b0) |-> (reg_rdata_o[2] == 1'b0 && reg_rdata_o[6] == 1'b0)); // R3
  AST_VALID_ON_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_fault_i |=> status[BIT_VLD]); // R5
  AST_VALID_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status == 8'h80) |-> !fault_pending_o); // R10
  AST_ADDR_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i && !data_fault_i) |=> $stable(fault_addr)); // R9
endmodule

// File: tb/tb_mpu_fault_status.sv
module tb_mpu_fault_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_f = 0, d_f = 0, st_f = 0, us_f = 0, fp_f = 0;
  logic [31:0] d_addr = '0;
  logic        wr = 0, sel = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pend;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  mpu_fault_status dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ifetch_fault_i(if_f), .data_fault_i(d_f), .data_addr_i(d_addr),
    .stack_fault_i(st_f), .unstack_fault_i(us_f), .fpstack_fault_i(fp_f),
    .reg_wr_i(wr), .reg_addr_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .fault_pending_o(pend)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // inputs already applied at a negedge; advance one edge and release them
  task automatic step();
    @(posedge clk); @(negedge clk);
    {if_f, d_f, st_f, us_f, fp_f, wr} = '0;
    wdata = '0;
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic wr_reg(input logic s, input logic [31:0] v);
    sel = s; wr = 1; wdata = v; step();
  endtask

  task automatic expect_regs(string req, logic [7:0] st, logic [31:0] ad, logic pd);
    logic [31:0] v;
    rd(1'b0, v); chk(req, "status", v, {24'h0, st});
    rd(1'b1, v); chk(req, "addr", v, ad);
    chk(req, "pending", {31'h0, pend}, {31'h0, pd});
  endtask

  task automatic t_reset();
    expect_regs("R1", 8'h00, 32'h0, 1'b0);
  endtask

  task automatic t_ifetch();
    if_f = 1; step();
    expect_regs("R2/R6", 8'h01, 32'h0, 1'b1);
    wr_reg(1'b0, 32'h01);
    expect_regs("R4", 8'h00, 32'h0, 1'b0);
  endtask

  task automatic t_others();
    st_f = 1; step();
    expect_regs("R2/R6 stack", 8'h10, 32'h0, 1'b1);
    us_f = 1; step();
    expect_regs("R2/R6 unstack", 8'h18, 32'h0, 1'b1);
    fp_f = 1; step();
    expect_regs("R2/R6 fpstack", 8'h38, 32'h0, 1'b1);
    wr_reg(1'b0, 32'h00);
    expect_regs("R4 zero write", 8'h38, 32'h0, 1'b1);
    wr_reg(1'b0, 32'h08);
    expect_regs("R4 partial", 8'h30, 32'h0, 1'b1);
    wr_reg(1'b0, 32'h30);
    expect_regs("R4 rest", 8'h00, 32'h0, 1'b0);
  endtask

  task automatic t_data();
    d_f = 1; d_addr = 32'h2000_1234; step();
    expect_regs("R5", 8'h82, 32'h2000_1234, 1'b1);
    wr_reg(1'b0, 32'h80);
    expect_regs("R11", 8'h02, 32'h2000_1234, 1'b1);
    d_f = 1; d_addr = 32'h2000_5678; step();
    wr_reg(1'b0, 32'h02);
    expect_regs("R10 valid only", 8'h80, 32'h2000_5678, 1'b0);
  endtask

  task automatic t_overwrite();
    d_f = 1; d_addr = 32'hCAFE_0010; step();
    expect_regs("R8 first", 8'h82, 32'hCAFE_0010, 1'b1);
    d_f = 1; d_addr = 32'hCAFE_0020; step();
    expect_regs("R8 second", 8'h82, 32'hCAFE_0020, 1'b1);
  endtask

  task automatic t_collision();
    d_f = 1; d_addr = 32'h4000_00A0; sel = 1'b0; wr = 1; wdata = 32'h82; step();
    expect_regs("R7", 8'h82, 32'h4000_00A0, 1'b1);
    if_f = 1; sel = 1'b0; wr = 1; wdata = 32'hFF; step();
    expect_regs("R7 ifetch", 8'h01, 32'h4000_00A0, 1'b1);
    wr_reg(1'b0, 32'hFF);
    expect_regs("R4 all", 8'h00, 32'h4000_00A0, 1'b0);
  endtask

  task automatic t_reserved();
    wr_reg(1'b0, 32'h44);
    expect_regs("R3 empty", 8'h00, 32'h4000_00A0, 1'b0);
    if_f = 1; d_f = 1; d_addr = 32'h1111_2222; st_f = 1; us_f = 1; fp_f = 1; step();
    expect_regs("R3 all set", 8'hBB, 32'h1111_2222, 1'b1);
    wr_reg(1'b0, 32'h44);
    expect_regs("R3 write rsvd", 8'hBB, 32'h1111_2222, 1'b1);
  endtask

  task automatic t_addr_ro();
    wr_reg(1'b1, 32'hDEAD_BEEF);
    expect_regs("R9", 8'hBB, 32'h1111_2222, 1'b1);
    wr_reg(1'b1, 32'hFFFF_FFFF);
    expect_regs("R9 no clear", 8'hBB, 32'h1111_2222, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ifetch();
    t_others();
    t_data();
    t_overwrite();
    t_collision();
    t_reserved();
    t_addr_ro();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule